// File: doc/BRIEF.md
# Cascaded Prescaler Reload Timer

This block divides a system-clock-domain count source in two down-counting stages: an 8-bit prescaler, then an 8-bit timer. Each stage has a reload latch. When a stage holds zero and receives a count tick, it underflows: it reloads from its latch and keeps counting. The prescaler's underflow is the timer's only count tick. A timer underflow raises a sticky interrupt request.

Software controls the block through address-select write strobes that share one data bus. A write to a stage loads that stage's latch and its live counter together. A one-bit select chooses which of two tick inputs drives the prescaler. Reads return the live counts. There is no way to stop the counting. A latch value of n gives a division by n+1, so the pair divides by (n+1)(m+1). A separate strobe clears the interrupt request.

Top module: `cpt_timer`

## Requirements
- R1: After reset, both live counts read 255, both reload latches hold 255, the interrupt request is 0 and the select is 0.
- R2: The prescaler decrements by one on each pulse of the selected tick input. Select 0 picks `src_a_tick_i` and select 1 picks `src_b_tick_i`. Pulses on the unselected input have no effect. A select write takes effect from the next cycle.
- R3: A stage that holds zero and receives a tick loads its latch value on that edge. With latch value n, the stage underflows once every n+1 ticks.
- R4: The timer changes only in a cycle where the prescaler underflows, or on a timer write. The first interrupt after writing n to the prescaler and m to the timer comes after (n+1)(m+1) selected ticks.
- R5: A write loads `wdata_i` into both the latch and the counter of the addressed stage. The write overrides a same-cycle tick, and that stage does not underflow in that cycle.
- R6: `pre_count_o` and `tmr_count_o` always show the live counter values, not the latch values.
- R7: A timer underflow sets `irq_o` on the same edge at which the timer reloads. `irq_o` then stays 1 until it is cleared.
- R8: `irq_clr_i` clears `irq_o` on the next edge. If a timer underflow occurs in the same cycle as the clear, `irq_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_tick_i | input | 1 | Tick pulses of source 0 |
| src_b_tick_i | input | 1 | Tick pulses of source 1 |
| sel_wr_i | input | 1 | Write strobe for the source select |
| sel_wdata_i | input | 1 | New source select value |
| pre_wr_i | input | 1 | Write strobe for the prescaler |
| tmr_wr_i | input | 1 | Write strobe for the timer |
| wdata_i | input | 8 | Write data for either stage |
| irq_clr_i | input | 1 | Clear strobe for the interrupt request |
| pre_count_o | output | 8 | Live prescaler count |
| tmr_count_o | output | 8 | Live timer count |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The bench checks the exact tick at which the first interrupt arrives after a reload. A design that underflows on reaching zero instead of one tick later would raise it after n·m ticks or fewer, not (n+1)(m+1). It drives a write in the same cycle as a tick, which exposes a design that decrements the just-written value. It also drives a clear in the same cycle as an underflow, which exposes a design that drops that interrupt. Pulses on the unselected source and a change of select part-way through catch a multiplexer that is inverted or not registered. Random traffic with latches of zero makes every tick an underflow, which exercises back-to-back reloads in both stages.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int unsigned CNT_W = 8;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_sel_e;
endpackage

// File: rtl/cpt_stage.sv
module cpt_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic         uflow_o
);
  logic [W-1:0] latch_q, count_q;
  logic         at_zero;

  assign at_zero = (count_q == '0);
  assign uflow_o = tick_i & ~wr_i & at_zero;
  assign count_o = count_q;

  // write beats decrement and reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      count_q <= '1;
    end else if (wr_i) begin
      latch_q <= wdata_i;
      count_q <= wdata_i;
    end else if (tick_i) begin
      count_q <= at_zero ? latch_q : count_q - 1'b1;
    end
  end

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && count_q != '0) |=> count_q == W'($past(count_q) - 1'b1));
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && count_q == '0) |=> count_q == $past(latch_q));
  assert_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (count_q == $past(wdata_i)) && (latch_q == $past(wdata_i)));
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(count_q) && $stable(latch_q));
endmodule

// File: rtl/cpt_irq_flag.sv
module cpt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (set_i)  irq_q <= 1'b1;
    else if (clr_i)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_q);
  assert_irq_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_q);
  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(irq_q));
endmodule

// File: rtl/cpt_timer.sv
module cpt_timer
  import cpt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         src_a_tick_i,
  input  logic         src_b_tick_i,
  input  logic         sel_wr_i,
  input  logic         sel_wdata_i,
  input  logic         pre_wr_i,
  input  logic         tmr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         irq_clr_i,
  output logic [W-1:0] pre_count_o,
  output logic [W-1:0] tmr_count_o,
  output logic         irq_o
);
  src_sel_e sel_q;
  logic     pre_tick, pre_uflow, tmr_uflow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SRC_A;
    else if (sel_wr_i) sel_q <= src_sel_e'(sel_wdata_i);
  end

  assign pre_tick = (sel_q == SRC_B) ? src_b_tick_i : src_a_tick_i;

  cpt_stage #(.W(W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (pre_tick),
    .wr_i    (pre_wr_i),
    .wdata_i (wdata_i),
    .count_o (pre_count_o),
    .uflow_o (pre_uflow)
  );

  // timer is clocked only by prescaler underflow
  cpt_stage #(.W(W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (pre_uflow),
    .wr_i    (tmr_wr_i),
    .wdata_i (wdata_i),
    .count_o (tmr_count_o),
    .uflow_o (tmr_uflow)
  );

  cpt_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tmr_uflow),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assert_unsel_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SRC_A && !src_a_tick_i && !pre_wr_i) |=> $stable(pre_count_o));
  assert_tmr_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_uflow && !tmr_wr_i) |=> $stable(tmr_count_o));
  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pre_uflow));
endmodule

// File: tb/tb_cpt_timer.sv
module tb_cpt_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       a_t = 0, b_t = 0, sel_wr = 0, sel_wd = 0, pre_wr = 0, tmr_wr = 0, clr = 0;
  logic [7:0] wd = '0;
  logic [7:0] pre_cnt, tmr_cnt;
  logic       irq;

  int tests = 0, fails = 0;

  // reference model state
  logic [7:0] m_pre = 8'hFF, m_pre_l = 8'hFF, m_tmr = 8'hFF, m_tmr_l = 8'hFF;
  logic       m_irq = 0, m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .src_a_tick_i(a_t), .src_b_tick_i(b_t),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd), .pre_wr_i(pre_wr), .tmr_wr_i(tmr_wr),
    .wdata_i(wd), .irq_clr_i(clr), .pre_count_o(pre_cnt), .tmr_count_o(tmr_cnt),
    .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(logic [7:0] c, logic [7:0] l, logic tk, logic w, logic [7:0] d);
    if (w) return d;
    if (tk) return (c == 0) ? l : c - 8'd1;
    return c;
  endfunction

  task automatic step(bit a, bit b, bit pw, bit tw, bit sw, bit swd, logic [7:0] d, bit cl);
    logic tk, puf, tuf;
    logic [7:0] np, nt, npl, ntl;
    logic ni, ns;
    @(negedge clk);
    a_t = a; b_t = b; pre_wr = pw; tmr_wr = tw; sel_wr = sw; sel_wd = swd; wd = d; clr = cl;
    tk  = m_sel ? b : a;
    puf = tk && !pw && (m_pre == 0);
    tuf = puf && !tw && (m_tmr == 0);
    np  = nxt(m_pre, m_pre_l, tk, pw, d);
    nt  = nxt(m_tmr, m_tmr_l, puf, tw, d);
    npl = pw ? d : m_pre_l;
    ntl = tw ? d : m_tmr_l;
    ni  = tuf ? 1'b1 : (cl ? 1'b0 : m_irq);
    ns  = sw ? swd : m_sel;
    @(posedge clk);
    #1;
    m_pre = np; m_tmr = nt; m_pre_l = npl; m_tmr_l = ntl; m_irq = ni; m_sel = ns;
    chk("R2/R6 pre", pre_cnt, m_pre);
    chk("R4/R6 tmr", tmr_cnt, m_tmr);
    chk("R7 irq", irq, m_irq);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 8'd0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int first_irq;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 pre", pre_cnt, 255);
    chk("R1 tmr", tmr_cnt, 255);
    chk("R1 irq", irq, 0);

    // R4 cascade period: n=2, m=1 -> 6 ticks
    step(0, 0, 1, 0, 0, 0, 8'd2, 0);
    step(0, 0, 0, 1, 0, 0, 8'd1, 0);
    first_irq = 0;
    for (int k = 1; k <= 8; k++) begin
      step(1, 0, 0, 0, 0, 0, 8'd0, 0);
      if (irq && first_irq == 0) first_irq = k;
    end
    chk("R4 first irq tick", first_irq, 6);
    // after 8 ticks: pre reloaded to 2 at tick 6, then 1, 0
    chk("R3 pre after reload", pre_cnt, 0);
    step(1, 0, 0, 0, 0, 0, 8'd0, 0);
    chk("R3 pre reload to latch", pre_cnt, 2);

    // R7 sticky
    idle(); idle();
    chk("R7 sticky", irq, 1);

    // R2 unselected source ignored
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 0, 8'd0, 0);
    chk("R2 B ignored when A selected", pre_cnt, 2);
    step(0, 0, 0, 0, 1, 1, 8'd0, 0);
    step(1, 1, 0, 0, 0, 0, 8'd0, 0);
    chk("R2 B counts when selected", pre_cnt, 1);
    step(1, 0, 0, 0, 0, 0, 8'd0, 0);
    chk("R2 A ignored when B selected", pre_cnt, 1);

    // R5 write beats same-cycle tick
    step(0, 1, 1, 0, 0, 0, 8'd7, 0);
    chk("R5 write wins", pre_cnt, 7);
    step(0, 1, 0, 0, 0, 0, 8'd0, 0);
    chk("R5 latch loaded", pre_cnt, 6);

    // R8 clear and clear-vs-set
    step(0, 0, 0, 0, 0, 0, 8'd0, 1);
    chk("R8 clear", irq, 0);
    step(0, 0, 1, 0, 0, 0, 8'd0, 0);
    step(0, 0, 0, 1, 0, 0, 8'd0, 0);
    step(0, 1, 0, 0, 0, 0, 8'd0, 0);
    chk("R7 set on underflow", irq, 1);
    step(0, 1, 0, 0, 0, 0, 8'd0, 1);
    chk("R8 set wins over clear", irq, 1);
    step(0, 0, 0, 0, 0, 0, 8'd0, 1);
    chk("R8 clear alone", irq, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 49) == 0), ($urandom_range(0, 49) == 0),
           ($urandom_range(0, 99) == 0), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 4)), ($urandom_range(0, 19) == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule